// File: doc/BRIEF.md
# Next-Fetch-Address Selector

This block holds the instruction fetch address of a front end and decides, every cycle, where the next fetch group starts and how many instructions it carries. Four redirect sources can each offer an address: an exception vector, a correction from the branch unit, a correction raised at decode against an earlier target-cache guess, and a hit in the branch target cache. They are ranked in that order. When none is active, the address steps forward past the group just fetched.

A group carries at most four 32-bit instructions and never straddles a 32-byte cache block. When fewer than four words remain before the block end, the group is shortened to what remains. The following sequential group then starts at the block start with a full count. A stall freezes the address, but the two highest-priority redirects still take effect while stalled. Either of them also raises a flush request toward the instruction buffer in the same cycle. Sequential fetch does not depend on buffer space.

Top module: `fetch_addr_sel`

## Requirements
- R1: While reset is held, `fetch_addr` equals the reset vector (default 0x114), and `fetch_count` reflects that address (3 for the default).
- R2: When `exc_valid` is high, the next `fetch_addr` is `exc_addr`, whatever the other inputs are, `stall` included.
- R3: When `bu_fix_valid` is high and `exc_valid` is low, the next `fetch_addr` is `bu_fix_addr`, even while `stall` is high.
- R4: When `dec_fix_valid` is high, `exc_valid`, `bu_fix_valid` and `stall` are low, the next `fetch_addr` is `dec_fix_addr`, taking precedence over a target-cache hit.
- R5: When `tgt_hit_valid` is the only active redirect and `stall` is low, the next `fetch_addr` is `tgt_hit_addr`.
- R6: With no redirect and no stall, the next `fetch_addr` is the current address plus 4 × `fetch_count`.
- R7: `fetch_count` equals min(4, words left before the end of the 32-byte block holding `fetch_addr`). For example, offset 0x18 gives 2 and offset 0x1C gives 1.
- R8: Sequential fetch after a shortened group starts at the next block boundary with `fetch_count` = 4.
- R9: While `stall` is high and neither `exc_valid` nor `bu_fix_valid` is high, `fetch_addr` holds its value. `dec_fix_valid` and `tgt_hit_valid` have no effect in that case.
- R10: `flush` is high in exactly those cycles in which `exc_valid` or `bu_fix_valid` is high.
- R11: Every redirect address is taken with its two low bits cleared, so `fetch_addr` is always word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Hold the fetch address |
| exc_valid | input | 1 | Exception redirect request |
| exc_addr | input | ADDR_W | Exception vector address |
| bu_fix_valid | input | 1 | Branch unit correction request |
| bu_fix_addr | input | ADDR_W | Branch unit corrected address |
| dec_fix_valid | input | 1 | Decode-stage correction request |
| dec_fix_addr | input | ADDR_W | Decode-stage corrected address |
| tgt_hit_valid | input | 1 | Branch target cache hit |
| tgt_hit_addr | input | ADDR_W | Predicted target address |
| fetch_addr | output | ADDR_W | Current fetch group start address |
| fetch_count | output | 3 | Instructions in the current group (1..4) |
| flush | output | 1 | Flush request to the instruction buffer |

## Verification
The assertions assume that reset is applied synchronously for at least one clock. They also assume that the redirect inputs are stable around the rising edge. Any combination of valid bits, including all four at once and redirects during a stall, is legal, and the checks treat the priority as total. The stimulus drives all inputs on the falling edge. It mixes directed collisions between sources and between stall and redirect with a long random run. In that run, redirect addresses land at every word offset of a block and sometimes carry nonzero low bits.

// File: rtl/fetch_addr_sel.sv
module fetch_addr_sel #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int GROUP_MAX   = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC = 'h114
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              exc_valid,
  input  logic [ADDR_W-1:0] exc_addr,
  input  logic              bu_fix_valid,
  input  logic [ADDR_W-1:0] bu_fix_addr,
  input  logic              dec_fix_valid,
  input  logic [ADDR_W-1:0] dec_fix_addr,
  input  logic              tgt_hit_valid,
  input  logic [ADDR_W-1:0] tgt_hit_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [2:0]        fetch_count,
  output logic              flush
);
  localparam int WB          = $clog2(WORD_BYTES);
  localparam int OFF_W       = $clog2(BLOCK_BYTES);
  localparam int BLOCK_WORDS = BLOCK_BYTES / WORD_BYTES;
  localparam int LEFT_W      = $clog2(BLOCK_WORDS + 1);

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:WB], {WB{1'b0}}};
  endfunction

  logic [OFF_W-WB-1:0] word_idx;
  logic [LEFT_W-1:0]   words_left;
  logic [ADDR_W-1:0]   seq_addr;
  logic [ADDR_W-1:0]   next_addr;

  assign word_idx    = fetch_addr[OFF_W-1:WB];
  assign words_left  = LEFT_W'(BLOCK_WORDS) - LEFT_W'(word_idx);
  assign fetch_count = (words_left > LEFT_W'(GROUP_MAX)) ? 3'(GROUP_MAX) : 3'(words_left);
  assign seq_addr    = fetch_addr + (ADDR_W'(fetch_count) << WB);
  assign flush       = exc_valid | bu_fix_valid;

  always_comb begin
    if (exc_valid)          next_addr = word_align(exc_addr);
    else if (bu_fix_valid)  next_addr = word_align(bu_fix_addr);
    else if (stall)         next_addr = fetch_addr;
    else if (dec_fix_valid) next_addr = word_align(dec_fix_addr);
    else if (tgt_hit_valid) next_addr = word_align(tgt_hit_addr);
    else                    next_addr = seq_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fetch_addr <= word_align(RESET_VEC);
    else        fetch_addr <= next_addr;
  end
endmodule

module fetch_addr_sel_chk #(
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int BLOCK_BYTES = 32,
  parameter int GROUP_MAX   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              exc_valid,
  input logic [ADDR_W-1:0] exc_addr,
  input logic              bu_fix_valid,
  input logic [ADDR_W-1:0] bu_fix_addr,
  input logic              dec_fix_valid,
  input logic [ADDR_W-1:0] dec_fix_addr,
  input logic              tgt_hit_valid,
  input logic [ADDR_W-1:0] tgt_hit_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [2:0]        fetch_count,
  input logic              flush
);
  localparam int WB    = $clog2(WORD_BYTES);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(WORD_BYTES - 1);

  a_r2_exc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> fetch_addr == ($past(exc_addr) & MASK));
  a_r3_bu_second: assert property (@(posedge clk) disable iff (!rst_n)
    (bu_fix_valid && !exc_valid) |=> fetch_addr == ($past(bu_fix_addr) & MASK));
  a_r4_dec_third: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fix_valid && !exc_valid && !bu_fix_valid && !stall) |=> fetch_addr == ($past(dec_fix_addr) & MASK));
  a_r5_tgt_fourth: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_hit_valid && !dec_fix_valid && !exc_valid && !bu_fix_valid && !stall) |=> fetch_addr == ($past(tgt_hit_addr) & MASK));
  a_r6_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_valid && !bu_fix_valid && !dec_fix_valid && !tgt_hit_valid && !stall)
      |=> fetch_addr == $past(fetch_addr) + (ADDR_W'($past(fetch_count)) << WB));
  a_r7_group_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_count != 3'd0 && int'(fetch_count) <= GROUP_MAX &&
    int'(fetch_addr[OFF_W-1:0]) + int'(fetch_count) * WORD_BYTES <= BLOCK_BYTES);
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !exc_valid && !bu_fix_valid) |=> $stable(fetch_addr));
  a_r10_flush_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fetch_addr == ($past(exc_valid) ? ($past(exc_addr) & MASK) : ($past(bu_fix_addr) & MASK)));
  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_addr[WB-1:0] == '0);
endmodule

bind fetch_addr_sel fetch_addr_sel_chk #(
  .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BLOCK_BYTES(BLOCK_BYTES), .GROUP_MAX(GROUP_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall),
  .exc_valid(exc_valid), .exc_addr(exc_addr),
  .bu_fix_valid(bu_fix_valid), .bu_fix_addr(bu_fix_addr),
  .dec_fix_valid(dec_fix_valid), .dec_fix_addr(dec_fix_addr),
  .tgt_hit_valid(tgt_hit_valid), .tgt_hit_addr(tgt_hit_addr),
  .fetch_addr(fetch_addr), .fetch_count(fetch_count), .flush(flush)
);

// File: tb/test_fetch_addr_sel.sv
module test_fetch_addr_sel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, stall, exc_valid, bu_fix_valid, dec_fix_valid, tgt_hit_valid;
  logic [31:0] exc_addr, bu_fix_addr, dec_fix_addr, tgt_hit_addr, fetch_addr;
  logic [2:0] fetch_count;
  logic flush;

  fetch_addr_sel i_fetch_addr_sel (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .exc_valid(exc_valid), .exc_addr(exc_addr),
    .bu_fix_valid(bu_fix_valid), .bu_fix_addr(bu_fix_addr),
    .dec_fix_valid(dec_fix_valid), .dec_fix_addr(dec_fix_addr),
    .tgt_hit_valid(tgt_hit_valid), .tgt_hit_addr(tgt_hit_addr),
    .fetch_addr(fetch_addr), .fetch_count(fetch_count), .flush(flush)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] m_addr;
  string m_tag;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int unsigned m_cnt(input logic [31:0] a);
    int unsigned left;
    left = (32 - (a % 32)) / 4;
    return (left > 4) ? 4 : left;
  endfunction

  function automatic string algn_tag(input string t, input logic [31:0] a);
    return (a[1:0] != 2'b00) ? {t, "/R11"} : t;
  endfunction

  task automatic cyc(input bit st, input bit e, input logic [31:0] ea, input bit b, input logic [31:0] ba,
                     input bit d, input logic [31:0] da, input bit t, input logic [31:0] ta);
    stall = st; exc_valid = e; exc_addr = ea; bu_fix_valid = b; bu_fix_addr = ba;
    dec_fix_valid = d; dec_fix_addr = da; tgt_hit_valid = t; tgt_hit_addr = ta;
    #1;
    chk("R10 flush", 32'(flush), 32'(e | b));
    if (e)       begin m_addr = ea & ~32'h3; m_tag = algn_tag("R2 exc", ea); end
    else if (b)  begin m_addr = ba & ~32'h3; m_tag = algn_tag("R3 bu_fix", ba); end
    else if (st) begin m_tag = "R9 stall hold"; end
    else if (d)  begin m_addr = da & ~32'h3; m_tag = algn_tag("R4 dec_fix", da); end
    else if (t)  begin m_addr = ta & ~32'h3; m_tag = algn_tag("R5 tgt_hit", ta); end
    else begin
      m_tag = (m_cnt(m_addr) < 4) ? "R8 block resume" : "R6 sequential";
      m_addr = m_addr + 4 * m_cnt(m_addr);
    end
    @(negedge clk);
    chk(m_tag, fetch_addr, m_addr);
    chk("R7 count", 32'(fetch_count), m_cnt(m_addr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stall = 0;
    exc_valid = 0; bu_fix_valid = 0; dec_fix_valid = 0; tgt_hit_valid = 0;
    exc_addr = 0; bu_fix_addr = 0; dec_fix_addr = 0; tgt_hit_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", fetch_addr, 32'h114);
    chk("R1 reset count", 32'(fetch_count), 3);
    m_addr = 32'h114;
    rst_n = 1;
    idle(4);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 32'h218);
    idle(3);
    cyc(0, 0, 0, 0, 0, 1, 32'h404, 1, 32'h508);
    cyc(0, 0, 0, 1, 32'h61C, 1, 32'h704, 1, 32'h808);
    idle(2);
    cyc(0, 1, 32'h900, 1, 32'hA00, 1, 32'hB00, 1, 32'hC00);
    cyc(1, 0, 0, 0, 0, 1, 32'h1000, 1, 32'h1100);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 32'h1208, 0, 0, 0, 0);
    cyc(1, 1, 32'h1310, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 32'h31F, 0, 0);
    idle(2);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 32'h2A2B);
    idle(2);
    for (int i = 0; i < 4000; i++) begin
      automatic int unsigned r = $urandom % 100;
      cyc(($urandom % 5) == 0,
          r < 3, $urandom % 32'h4000,
          (r >= 3 && r < 8) || ($urandom % 40 == 0), $urandom % 32'h4000,
          ($urandom % 12) == 0, $urandom % 32'h4000,
          ($urandom % 7) == 0, $urandom % 32'h4000);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule